// File: doc/BRIEF.md
# Two-Pulse Slow-Time Clutter Canceller

This block removes stationary clutter from a streaming complex radar return. Samples arrive one range bin at a time, each qualified by a valid strobe and tagged with its range-bin index, and bin 0 marks the start of a new chirp. For every bin the block subtracts the sample it saw at that bin on the previous chirp. Along slow time this is the filter 1 − z⁻¹, which places a null at zero Doppler. The previous chirp is kept in a single-port history memory that is read before it is written. Each bin costs one memory access per sample.

A waveform flag tells the block whether the current chirp is long or short. Subtracting a chirp of one waveform from a chirp of the other produces garbage, so the first chirp after a change of waveform is muted to zero. The same happens to the first chirp after reset or after the enable is raised, since no valid history exists then. A muted chirp still refreshes the history, so the chirp after it subtracts cleanly. When the enable is low the samples pass through unchanged.

The difference is formed one bit wider than the data. When it does not fit it is clamped, and a saturating 8-bit counter records the event.

Top module: `mti_clutter_canceller`

## Requirements
- R1: With the enable high and the chirp not muted, each output equals current minus stored sample of the same bin from the previous chirp, for I and Q separately; identical consecutive chirps give all-zero outputs.
- R2: A sample presented while the enable is low comes out unchanged on I and Q and does not affect the saturation counter.
- R3: After reset the output valid is 0 and the counter is 0. The first enabled chirp after reset, or after any cycle with the enable low, has all outputs muted to zero.
- R4: A chirp that begins (bin 0) with a waveform flag different from the flag of the previous enabled chirp start has all its outputs muted to zero.
- R5: During a muted chirp every bin's history is still overwritten with the current sample, so the following chirp of the same waveform subtracts against the muted chirp's data.
- R6: The difference is computed at DATA_WIDTH+1 bits signed. When its top two bits disagree on I or Q, that component is clamped to the most positive or most negative DATA_WIDTH value (+32767 / −32768 by default), according to the sign.
- R7: The 8-bit counter increments by one for each output sample where I or Q saturates (at most one per sample), with no increment for muted or passed-through samples. It holds at 255.
- R8: The output valid equals the input valid delayed by exactly two clock edges, and the output bin index equals the input bin index of that sample.
- R9: The history holds 2^BIN_BITS = 512 independent bins addressed by the 9-bit bin index. Bin 0 starts a chirp; the mute decision is taken at bin 0 and held for the rest of the chirp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_bin | input | 9 | Range-bin index of the input sample |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| mti_on | input | 1 | Cancel enable; low gives pass-through |
| long_wave | input | 1 | 1 = current chirp uses the long waveform |
| out_valid | output | 1 | Output sample valid |
| out_bin | output | 9 | Range-bin index of the output sample |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |
| sat_count | output | 8 | Saturating count of clamped output samples |

## Verification
The hardest condition to reach from the ports is a saturation count that has reached its ceiling and must hold there. It needs more than 255 clamped samples, and each of them needs valid history of the opposite extreme. The bench first sends a muted 512-bin chirp of alternating full-scale values, which also seeds every history entry up to bin 511. It then sends chirps with the extremes swapped, so every sample overflows on both I and Q. This drives the counter past 255, and the bench then checks that it holds.

// File: rtl/mti_pkg.sv
package mti_pkg;
  typedef enum logic [1:0] {
    OUT_PASS = 2'd0,
    OUT_MUTE = 2'd1,
    OUT_DIFF = 2'd2
  } out_kind_e;
endpackage

// File: rtl/mti_history_ram.sv
module mti_history_ram #(
  parameter int ADDR_BITS = 9,
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [WORD_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WORD_BITS-1:0] mem [DEPTH];

  // read-first: rdata gets the old word when the same address is written
  always_ff @(posedge clk) begin
    rdata <= mem[addr];
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/mti_boundary_ctrl.sv
module mti_boundary_ctrl #(
  parameter int BIN_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                valid,
  input  logic [BIN_BITS-1:0] bin,
  input  logic                long_wave,
  output logic                mute_now,
  output logic                chirp_start
);
  logic hist_ok;
  logic last_long;
  logic chirp_mute;

  assign chirp_start = valid && (bin == '0);

  always_comb begin
    if (chirp_start) mute_now = !hist_ok || (long_wave != last_long);
    else             mute_now = chirp_mute;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_ok    <= 1'b0;
      last_long  <= 1'b0;
      chirp_mute <= 1'b0;
    end else begin
      if (chirp_start) chirp_mute <= mute_now;
      if (!en) begin
        hist_ok <= 1'b0;
      end else if (chirp_start) begin
        hist_ok   <= 1'b1;
        last_long <= long_wave;
      end
    end
  end

  AST_NO_HISTORY_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_start && en && $past(!en)) |-> mute_now); // R3
  AST_WAVE_CHANGE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_start && hist_ok && long_wave != last_long) |-> mute_now); // R4
  AST_MUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && bin != '0 && !$past(chirp_start)) |-> $stable(chirp_mute)); // R9
endmodule

// File: rtl/mti_sat_counter.sv
module mti_sat_counter #(
  parameter int CNT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  output logic [CNT_BITS-1:0] count
);
  localparam logic [CNT_BITS-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                       count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  AST_SAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1)); // R7
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == CNT_MAX) |-> (count == CNT_MAX)); // R7
endmodule

// File: rtl/mti_clutter_canceller.sv
module mti_clutter_canceller #(
  parameter int DATA_WIDTH = 16,
  parameter int BIN_BITS   = 9,
  parameter int CNT_BITS   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [BIN_BITS-1:0]          in_bin,
  input  logic signed [DATA_WIDTH-1:0] in_i,
  input  logic signed [DATA_WIDTH-1:0] in_q,
  input  logic                         mti_on,
  input  logic                         long_wave,
  output logic                         out_valid,
  output logic [BIN_BITS-1:0]          out_bin,
  output logic signed [DATA_WIDTH-1:0] out_i,
  output logic signed [DATA_WIDTH-1:0] out_q,
  output logic [CNT_BITS-1:0]          sat_count
);
  import mti_pkg::*;

  localparam int WIDE  = DATA_WIDTH + 1;
  localparam int WORD  = 2 * DATA_WIDTH;
  localparam logic signed [DATA_WIDTH-1:0] MAXV = {1'b0, {(DATA_WIDTH-1){1'b1}}};
  localparam logic signed [DATA_WIDTH-1:0] MINV = {1'b1, {(DATA_WIDTH-1){1'b0}}};

  // ---- arithmetic helpers --------------------------------------------------
  function automatic logic signed [WIDE-1:0] wide_diff(
    input logic signed [DATA_WIDTH-1:0] a,
    input logic signed [DATA_WIDTH-1:0] b);
    return WIDE'(a) - WIDE'(b);
  endfunction

  function automatic logic overflows(input logic signed [WIDE-1:0] d);
    return d[WIDE-1] != d[WIDE-2];
  endfunction

  function automatic logic signed [DATA_WIDTH-1:0] clamp(input logic signed [WIDE-1:0] d);
    if (!overflows(d)) return d[DATA_WIDTH-1:0];
    return d[WIDE-1] ? MINV : MAXV;
  endfunction

  // ---- stage 0: boundary decision and history access ----------------------
  logic            mute_now;
  logic            chirp_start;
  logic [WORD-1:0] hist_rd;

  mti_boundary_ctrl #(.BIN_BITS(BIN_BITS)) u_bound (
    .clk(clk), .rst_n(rst_n), .en(mti_on), .valid(in_valid), .bin(in_bin),
    .long_wave(long_wave), .mute_now(mute_now), .chirp_start(chirp_start)
  );

  mti_history_ram #(.ADDR_BITS(BIN_BITS), .WORD_BITS(WORD)) u_hist (
    .clk(clk), .we(in_valid), .addr(in_bin), .wdata({in_i, in_q}), .rdata(hist_rd)
  );

  // ---- stage 1 registers ----------------------------------------------------
  logic                         s1_valid;
  logic [BIN_BITS-1:0]          s1_bin;
  logic signed [DATA_WIDTH-1:0] s1_i, s1_q;
  out_kind_e                    s1_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_bin   <= '0;
      s1_i     <= '0;
      s1_q     <= '0;
      s1_kind  <= OUT_PASS;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_bin  <= in_bin;
        s1_i    <= in_i;
        s1_q    <= in_q;
        s1_kind <= !mti_on ? OUT_PASS : (mute_now ? OUT_MUTE : OUT_DIFF);
      end
    end
  end

  // ---- stage 1 arithmetic ---------------------------------------------------
  logic signed [DATA_WIDTH-1:0] prev_i, prev_q;
  logic signed [WIDE-1:0]       diff_i, diff_q;
  logic                         sat_evt;
  logic signed [DATA_WIDTH-1:0] res_i, res_q;

  assign prev_i  = hist_rd[WORD-1:DATA_WIDTH];
  assign prev_q  = hist_rd[DATA_WIDTH-1:0];
  assign diff_i  = wide_diff(s1_i, prev_i);
  assign diff_q  = wide_diff(s1_q, prev_q);
  assign sat_evt = s1_valid && (s1_kind == OUT_DIFF) && (overflows(diff_i) || overflows(diff_q));

  always_comb begin
    unique case (s1_kind)
      OUT_PASS: begin res_i = s1_i;          res_q = s1_q;          end
      OUT_MUTE: begin res_i = '0;            res_q = '0;            end
      default:  begin res_i = clamp(diff_i); res_q = clamp(diff_q); end
    endcase
  end

  // ---- stage 2: output registers --------------------------------------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_bin <= s1_bin;
        out_i   <= res_i;
        out_q   <= res_q;
      end
    end
  end

  mti_sat_counter #(.CNT_BITS(CNT_BITS)) u_sat (
    .clk(clk), .rst_n(rst_n), .inc(sat_evt), .count(sat_count)
  );

  // ---- assertions -----------------------------------------------------------
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2)); // R8
  AST_BIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bin == $past(in_bin, 2)); // R8
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mti_on, 2)) |-> (out_i == $past(in_i, 2) && out_q == $past(in_q, 2))); // R2
  AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> (out_i == MAXV || out_i == MINV || out_q == MAXV || out_q == MINV)); // R6
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == OUT_MUTE) |=> (out_i == '0 && out_q == '0)); // R4
endmodule

// File: tb/mti_clutter_canceller_test.sv
module mti_clutter_canceller_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [8:0] in_bin = '0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic mti_on = 1'b0, long_wave = 1'b0;
  logic out_valid;
  logic [8:0] out_bin;
  logic signed [15:0] out_i, out_q;
  logic [7:0] sat_count;

  always #2.5 clk = ~clk; // 200 MHz

  mti_clutter_canceller uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin),
    .in_i(in_i), .in_q(in_q), .mti_on(mti_on), .long_wave(long_wave),
    .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q),
    .sat_count(sat_count)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int due; int bin; int i; int q; int cnt; string tag;
  } exp_t;
  exp_t expq[$];

  // behavioural reference state
  int hist_i [512];
  int hist_q [512];
  bit m_ok = 0, m_long = 0, m_mute = 0, last_was_mute = 0;
  int m_cnt = 0;
  int edges = 0;

  always @(posedge clk) begin
    edges++;
    if (rst_n) begin
      if (in_valid) begin
        exp_t e;
        bit mute;
        string why;
        int ci, cq, di, dq;
        bit sat;
        ci = in_i; cq = in_q;
        why = "";
        if (in_bin == 0) begin
          mute = !m_ok || (long_wave != m_long);
          why = !m_ok ? "R3" : "R4";
        end else mute = m_mute;
        e.due = edges + 1; e.bin = in_bin;
        if (!mti_on) begin
          e.i = ci; e.q = cq; e.tag = "R2";
        end else if (mute) begin
          e.i = 0; e.q = 0; e.tag = (why == "") ? "R4" : why;
        end else begin
          di = ci - hist_i[in_bin]; dq = cq - hist_q[in_bin];
          sat = 0;
          if (di > 32767)  begin di = 32767;  sat = 1; end
          if (di < -32768) begin di = -32768; sat = 1; end
          if (dq > 32767)  begin dq = 32767;  sat = 1; end
          if (dq < -32768) begin dq = -32768; sat = 1; end
          if (sat && m_cnt < 255) m_cnt++;
          e.i = di; e.q = dq;
          e.tag = sat ? "R6" : (in_bin > 255 ? "R9" : (last_was_mute ? "R5" : "R1"));
        end
        e.cnt = m_cnt;
        expq.push_back(e);
        if (in_bin == 0) begin
          m_mute = mute;
          last_was_mute = mti_on && mute;
        end
        hist_i[in_bin] = ci; hist_q[in_bin] = cq;
      end
      if (!mti_on) m_ok = 0;
      else if (in_valid && in_bin == 0) begin m_ok = 1; m_long = long_wave; end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expq.size() > 0 && expq[0].due == edges) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (out_valid !== 1'b1 || out_bin != e.bin) begin
          failures++;
          $display("FAIL R8 valid/bin: got v=%0b bin=%0d exp v=1 bin=%0d", out_valid, out_bin, e.bin);
        end else if (out_i != e.i || out_q != e.q) begin
          failures++;
          $display("FAIL %s bin %0d: got (%0d,%0d) exp (%0d,%0d)", e.tag, e.bin, out_i, out_q, e.i, e.q);
        end
        checks++;
        if (sat_count != e.cnt) begin
          failures++;
          $display("FAIL R7 sat_count: got %0d exp %0d", sat_count, e.cnt);
        end
      end else if (out_valid !== 1'b0) begin
        checks++; failures++;
        $display("FAIL R8 unexpected out_valid: got %0b exp 0", out_valid);
      end
    end
  end

  function automatic int gen_i(int mode, int bin, int k);
    case (mode)
      0: return bin * 100 - 3000;
      1: return bin * 100 - 3000 + k * 111;
      default: return ((bin + k) % 2 == 1) ? 32767 : -32768;
    endcase
  endfunction

  function automatic int gen_q(int mode, int bin, int k);
    case (mode)
      0: return 500 - bin * 37;
      1: return 500 - bin * 37 - k * 53;
      default: return ((bin + k) % 2 == 1) ? -32768 : 32767;
    endcase
  endfunction

  task automatic send_chirp(int n, bit en, bit lw, int mode, int k, bit gaps);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bin = b[8:0];
      in_i = 16'(gen_i(mode, b, k)); in_q = 16'(gen_q(mode, b, k));
      mti_on = en; long_wave = lw;
      if (gaps && b % 5 == 4) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R3 reset state
    checks++;
    if (out_valid !== 1'b0 || sat_count !== 8'd0) begin
      failures++;
      $display("FAIL R3 reset: got v=%0b cnt=%0d exp v=0 cnt=0", out_valid, sat_count);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_chirp(16, 0, 1, 1, 0, 0);   // R2 pass-through
    send_chirp(16, 1, 1, 0, 0, 0);   // R3 first enabled chirp muted
    send_chirp(16, 1, 1, 0, 0, 1);   // R1 stationary -> zeros
    send_chirp(16, 1, 1, 1, 3, 1);   // R1 moving
    send_chirp(16, 1, 0, 1, 7, 0);   // R4 waveform change muted
    send_chirp(16, 1, 0, 1, 9, 0);   // R5 clean after muted refresh
    send_chirp(16, 1, 1, 1, 2, 0);   // R4 back to long
    send_chirp(16, 1, 1, 1, 4, 0);   // R5
    send_chirp(16, 0, 1, 1, 5, 0);   // R2 disabled
    send_chirp(16, 1, 1, 1, 6, 0);   // R3 re-enable muted
    send_chirp(16, 1, 1, 0, 0, 0);   // R1
    send_chirp(512, 1, 0, 2, 0, 0);  // R4 mute, seeds all 512 bins (R9)
    send_chirp(512, 1, 0, 2, 1, 0);  // R6/R7 saturating
    send_chirp(512, 1, 0, 2, 0, 0);  // R7 hold at 255
    send_chirp(512, 1, 0, 1, 8, 0);  // R9 wide bins, moderate values
    repeat (5) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL R8 outputs missing: got %0d pending exp 0", expq.size());
    end
    checks++;
    if (sat_count != 8'd255) begin
      failures++;
      $display("FAIL R7 final count: got %0d exp 255", sat_count);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule